// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit counting channel of an interval timer. A slow input clock enable, sampled in the system clock domain, steps a down-counter. The counter runs in one of two periodic modes. In the rate mode the channel output pulses low once per period. In the square mode it produces a square wave whose halves are as nearly equal as the count allows. A terminal-count interrupt is a one-cycle pulse that fires when the output rises. With a 1.193 MHz enable and the largest count, it fires roughly 18.2 times a second.

The host uses a byte-wide bus with two addresses. The control address takes two kinds of word. One selects the mode and halts the counter. The other freezes a snapshot of the count. The data address takes the initial count as two writes and returns the count as two reads. A snapshot lets the host read a moving count as one consistent value, without stopping the channel.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is high, the interrupt is low, the mode is rate, the stored count is 0 and the count reads back as 0. Clock enables have no effect until a full initial count (low byte, then high byte) has been written.
- R2: A write to data address 0 stores the low byte and the next write stores the high byte. The counter loads the new count on the first clock enable after the high-byte write. A low-byte write alone leaves the running count undisturbed.
- R3: In rate mode (control bit 0 = 0) with count N ≥ 2, the output stays high for N-1 enables, then low for exactly 1 enable, and the count reloads.
- R4: In square mode (control bit 0 = 1) with even N ≥ 2, the counter steps down by two per enable, and the output is high for N/2 enables and low for N/2 enables.
- R5: In square mode with odd N ≥ 3, the high half lasts (N+1)/2 enables and the low half (N-1)/2.
- R6: An initial count of 0 acts as 65536. In rate mode the count reads 0x0000 after loading and 0xFFFF one enable later. In square mode it reads 0x0000 after loading and 0xFFFE one enable later.
- R7: The interrupt is high for exactly one system clock, in the cycle after each rising edge of the output, and at no other time.
- R8: A control write with bit 7 = 1 is a latch command. It captures the live count, and the following two reads at data address 0 return that captured value, low byte first, while the counter keeps running.
- R9: The captured value is released after its high byte is read. A latch command issued while a capture is still unread is ignored.
- R10: A control write with bit 7 = 0 sets the mode from bit 0 and ignores bits 6..1. It halts the counter with the output high, clears any capture, and resets both byte pointers. The count stays frozen until a new full count is written.
- R11: With no capture pending, reads at data address 0 return the live count, low byte then high byte in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Input clock enable, one system cycle per counting step |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (advances the read byte pointer at data address 0) |
| host_addr | input | 1 | 0 = count data, 1 = control word |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected count byte (0 when host_addr is 1) |
| chan_out | output | 1 | Channel output waveform |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
A corrupted count or a wrong reload value shows up at chan_out within one period. The high or low half of the waveform has the wrong number of enables at its very next edge. Because every rising edge is compared against an interrupt pulse in the same cycle, a wrong phase bit in square mode is caught one enable after the toggle. A byte pointer that is out of step, or a capture that is released or retaken at the wrong time, shows on host_rdata at the next read. The bench holds the count still between reads, so the expected bytes are exact.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic {
      PIT_RATE   = 1'b0,
      PIT_SQUARE = 1'b1
   } pit_mode_e;

   // control word fields
   localparam int CTL_LATCH_BIT = 7;
   localparam int CTL_MODE_BIT  = 0;

endpackage

// File: rtl/pit_host_regs.sv
module pit_host_regs
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic [CNT_W-1:0]  live_cnt,
   output logic [BYTE_W-1:0] host_rdata,
   output pit_mode_e         mode,
   output logic [CNT_W-1:0]  init_cnt,
   output logic              load_strobe,
   output logic              stop_strobe,
   output logic              latched,
   output logic [CNT_W-1:0]  snap_cnt
);

   localparam int NB    = CNT_W / BYTE_W;
   localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

   if (BYTE_W < 1 || (CNT_W % BYTE_W) != 0 || NB < 2) begin : g_bad_width
      $error("pit_host_regs: CNT_W must be a multiple of BYTE_W, at least two bytes");
   end
   if (BYTE_W <= CTL_LATCH_BIT) begin : g_bad_byte
      $error("pit_host_regs: BYTE_W too narrow for the control word");
   end

   logic [IDX_W-1:0]  wr_idx_q, rd_idx_q;
   logic [CNT_W-1:0]  stage_q, stage_nx, init_q, snap_q;
   logic              latched_q;
   pit_mode_e         mode_q;
   logic              ctl_wr, dat_wr, dat_rd, latch_cmd, mode_cmd;
   logic [CNT_W-1:0]  rd_src;
   logic [BYTE_W-1:0] rd_bytes [NB];

   assign ctl_wr    = host_wr &&  host_addr;
   assign dat_wr    = host_wr && !host_addr;
   assign dat_rd    = host_rd && !host_addr;
   assign latch_cmd = ctl_wr &&  host_wdata[CTL_LATCH_BIT];
   assign mode_cmd  = ctl_wr && !host_wdata[CTL_LATCH_BIT];

   always_comb begin
      stage_nx = stage_q;
      stage_nx[wr_idx_q*BYTE_W +: BYTE_W] = host_wdata;
   end

   assign rd_src = latched_q ? snap_q : live_cnt;

   for (genvar b = 0; b < NB; b++) begin : g_rd_byte
      assign rd_bytes[b] = rd_src[b*BYTE_W +: BYTE_W];
   end

   assign host_rdata = host_addr ? '0 : rd_bytes[rd_idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx_q  <= '0;
         rd_idx_q  <= '0;
         stage_q   <= '0;
         init_q    <= '0;
         snap_q    <= '0;
         latched_q <= 1'b0;
         mode_q    <= PIT_RATE;
      end else if (mode_cmd) begin
         mode_q    <= pit_mode_e'(host_wdata[CTL_MODE_BIT]);
         wr_idx_q  <= '0;
         rd_idx_q  <= '0;
         latched_q <= 1'b0;
      end else if (latch_cmd) begin
         if (!latched_q) begin
            latched_q <= 1'b1;
            snap_q    <= live_cnt;
            rd_idx_q  <= '0;
         end
      end else if (dat_wr) begin
         stage_q <= stage_nx;
         if (wr_idx_q == LAST_IDX) begin
            wr_idx_q <= '0;
            init_q   <= stage_nx;
         end else begin
            wr_idx_q <= wr_idx_q + 1'b1;
         end
      end else if (dat_rd) begin
         if (rd_idx_q == LAST_IDX) begin
            rd_idx_q  <= '0;
            latched_q <= 1'b0;
         end else begin
            rd_idx_q <= rd_idx_q + 1'b1;
         end
      end
   end

   assign load_strobe = dat_wr && (wr_idx_q == LAST_IDX);
   assign stop_strobe = mode_cmd;
   assign mode        = mode_q;
   assign init_cnt    = init_q;
   assign latched     = latched_q;
   assign snap_cnt    = snap_q;

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  pit_mode_e        mode,
   input  logic [CNT_W-1:0] init_cnt,
   input  logic             load_strobe,
   input  logic             stop_strobe,
   output logic [CNT_W-1:0] cnt,
   output logic             chan_out,
   output logic             running
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pit_down_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   logic [CNT_W-1:0] cnt_q, hi_load, lo_load, first_load;
   logic             out_q, run_q, pend_q;

   // square mode keeps every pass even; an odd count gives the high half
   // the extra enable
   assign hi_load    = init_cnt[0] ? init_cnt + ONE : init_cnt;
   assign lo_load    = init_cnt[0] ? init_cnt - ONE : init_cnt;
   assign first_load = (mode == PIT_SQUARE) ? hi_load : init_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         out_q  <= 1'b1;
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (stop_strobe) begin
         out_q  <= 1'b1;
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (load_strobe) begin
            pend_q <= 1'b1;
         end else if (tick) begin
            pend_q <= 1'b0;
         end

         if (tick) begin
            if (pend_q) begin
               run_q <= 1'b1;
               out_q <= 1'b1;
               cnt_q <= first_load;
            end else if (run_q) begin
               if (mode == PIT_RATE) begin
                  if (cnt_q == ONE) begin
                     cnt_q <= init_cnt;
                     out_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q - ONE;
                     if (cnt_q == TWO) begin
                        out_q <= 1'b0;
                     end
                  end
               end else begin
                  if (cnt_q == TWO) begin
                     out_q <= ~out_q;
                     cnt_q <= out_q ? lo_load : hi_load;
                  end else begin
                     cnt_q <= cnt_q - TWO;
                  end
               end
            end
         end
      end
   end

   assign cnt      = cnt_q;
   assign chan_out = out_q;
   assign running  = run_q;

endmodule

// File: rtl/pit_rise_pulse.sv
module pit_rise_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic pulse
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
      end else begin
         prev_q <= sig_in;
      end
   end

   assign pulse = sig_in & ~prev_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   output logic              chan_out,
   output logic              irq
);

   pit_mode_e        mode_w;
   logic [CNT_W-1:0] init_w, live_w, snap_w;
   logic             load_w, stop_w, latched_w, running_w;

   pit_host_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_rd     (host_rd),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .live_cnt    (live_w),
      .host_rdata  (host_rdata),
      .mode        (mode_w),
      .init_cnt    (init_w),
      .load_strobe (load_w),
      .stop_strobe (stop_w),
      .latched     (latched_w),
      .snap_cnt    (snap_w)
   );

   pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .mode        (mode_w),
      .init_cnt    (init_w),
      .load_strobe (load_w),
      .stop_strobe (stop_w),
      .cnt         (live_w),
      .chan_out    (chan_out),
      .running     (running_w)
   );

   pit_rise_pulse u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (chan_out),
      .pulse  (irq)
   );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              host_wr,
   input logic              host_addr,
   input logic [BYTE_W-1:0] host_wdata,
   input logic              chan_out,
   input logic              irq,
   input logic              mode_sq,
   input logic              running,
   input logic              latched,
   input logic [CNT_W-1:0]  snap_cnt
);

   logic ctl_mode_wr;
   assign ctl_mode_wr = host_wr && host_addr && !host_wdata[pit_pkg::CTL_LATCH_BIT];

   // R1: output held high while in reset
   a_r1_reset_high: assert property (@(posedge clk) !rst_n |=> chan_out);

   // R7: interrupt is a single cycle and only while the output is high
   a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r7_irq_out_high: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> chan_out);

   // R2: output moves only on an enable or a mode write
   a_r2_out_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ctl_mode_wr) |=> $stable(chan_out));

   // R3: rate mode low phase lasts one enable
   a_r3_low_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sq && running && !chan_out && tick && !ctl_mode_wr) |=> chan_out);

   // R9: a held capture never changes value
   a_r9_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      latched |=> (!latched || $stable(snap_cnt)));

   // R10: mode write halts with output high
   a_r10_mode_halts: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_mode_wr |=> (chan_out && !running && !latched));

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .chan_out   (chan_out),
   .irq        (irq),
   .mode_sq    (mode_w),
   .running    (running_w),
   .latched    (latched_w),
   .snap_cnt   (snap_w)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   typedef struct {
      logic  lvl;
      int    len;
      string tag;
   } seg_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic       host_addr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       chan_out;
   logic       irq;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   seg_t exp_q[$];
   seg_t mon_e;
   bit   mon_arm = 0;
   bit   mon_synced = 0;
   logic mon_last = 1'b1;
   int   mon_ticks = 0;
   logic prev_out = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   pit_channel u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .chan_out   (chan_out),
      .irq        (irq)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_addr = 1'b0;
   endtask

   task automatic rd_check(input logic [7:0] exp, input string req, input string what);
      @(negedge clk);
      host_rd = 1'b1; host_addr = 1'b0;
      #1;
      check(host_rdata === exp, req, what, host_rdata, exp);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic load_count(input logic [7:0] ctl, input int n);
      wr(1'b1, ctl);
      wr(1'b0, 8'(n));
      wr(1'b0, 8'(n >> 8));
      ticks(1);
   endtask

   // driver: loads a count and pushes the expected waveform halves
   task automatic run_segments(input logic [7:0] ctl, input int n, input int periods,
                               input string tag);
      int hi, lo;
      if (ctl[0]) begin
         hi = (n + 1) / 2; lo = n / 2;
      end else begin
         hi = n - 1; lo = 1;
      end
      load_count(ctl, n);
      mon_last = 1'b1; mon_ticks = 0; mon_synced = 0; mon_arm = 1;
      for (int p = 0; p < periods; p++) begin
         exp_q.push_back('{lvl: 1'b0, len: lo, tag: tag});
         exp_q.push_back('{lvl: 1'b1, len: hi, tag: tag});
      end
      ticks(hi + periods * n);
      @(negedge clk);
      mon_arm = 0;
      check(exp_q.size() == 0, tag, "halves not seen", exp_q.size(), 0);
      exp_q.delete();
      wr(1'b1, ctl);
   endtask

   // monitor: measures each finished half of the output and the interrupt
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         if (chan_out && !prev_out) begin
            check(irq === 1'b1, "R7", "irq on rise", irq, 1);
         end else if (irq !== 1'b0) begin
            check(1'b0, "R7", "irq without rise", irq, 0);
         end
         if (mon_arm) begin
            if (tick) mon_ticks++;
            if (chan_out !== mon_last) begin
               if (mon_synced) begin
                  if (exp_q.size() == 0) begin
                     check(1'b0, "R3", "unexpected edge", mon_ticks, 0);
                  end else begin
                     mon_e = exp_q.pop_front();
                     check(mon_last === mon_e.lvl, mon_e.tag, "half level", mon_last, mon_e.lvl);
                     check(mon_ticks == mon_e.len, mon_e.tag, "half length", mon_ticks, mon_e.len);
                  end
               end
               mon_synced = 1;
               mon_ticks = 0;
               mon_last = chan_out;
            end
         end
      end
      prev_out = rst_n ? chan_out : 1'b1;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         check(1'b0, "WATCHDOG", "run timed out", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(chan_out === 1'b1, "R1", "out after reset", chan_out, 1);
      check(irq === 1'b0, "R1", "irq after reset", irq, 0);
      rd_check(8'h00, "R1", "reset count low");
      rd_check(8'h00, "R1", "reset count high");
      ticks(4);
      check(chan_out === 1'b1, "R1", "idle out", chan_out, 1);
      rd_check(8'h00, "R1", "idle count low");
      rd_check(8'h00, "R1", "idle count high");

      // R2 low byte alone does not start counting
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h05);
      ticks(3);
      rd_check(8'h00, "R2", "partial write idle low");
      rd_check(8'h00, "R2", "partial write idle high");
      wr(1'b0, 8'h00);
      ticks(1);
      rd_check(8'h05, "R11", "live low after load");
      rd_check(8'h00, "R11", "live high after load");
      ticks(2);
      rd_check(8'h03, "R11", "live low after two");
      rd_check(8'h00, "R11", "live high after two");
      wr(1'b0, 8'h20);
      ticks(1);
      rd_check(8'h02, "R2", "old count runs on");
      rd_check(8'h00, "R2", "old count high");
      wr(1'b0, 8'h00);
      rd_check(8'h02, "R2", "no load before tick");
      rd_check(8'h00, "R2", "no load before tick high");
      ticks(1);
      rd_check(8'h20, "R2", "restart low");
      rd_check(8'h00, "R2", "restart high");
      wr(1'b1, 8'h00);

      // waveform halves
      run_segments(8'h00, 5, 3, "R3");
      run_segments(8'h7E, 2, 2, "R3");
      run_segments(8'h01, 6, 2, "R4");
      run_segments(8'h01, 4, 2, "R4");
      run_segments(8'h41, 7, 2, "R5");
      run_segments(8'h01, 3, 2, "R5");

      // R6 zero count
      load_count(8'h00, 0);
      rd_check(8'h00, "R6", "rate zero low");
      rd_check(8'h00, "R6", "rate zero high");
      ticks(1);
      rd_check(8'hFF, "R6", "rate wrap low");
      rd_check(8'hFF, "R6", "rate wrap high");
      load_count(8'h01, 0);
      rd_check(8'h00, "R6", "square zero low");
      rd_check(8'h00, "R6", "square zero high");
      ticks(1);
      rd_check(8'hFE, "R6", "square wrap low");
      rd_check(8'hFF, "R6", "square wrap high");

      // R8 / R9 capture
      load_count(8'h00, 1000);
      ticks(10);
      wr(1'b1, 8'h80);
      ticks(5);
      rd_check(8'hDE, "R8", "snapshot low");
      ticks(3);
      wr(1'b1, 8'h80);
      rd_check(8'h03, "R9", "second latch ignored");
      rd_check(8'hD6, "R9", "released live low");
      rd_check(8'h03, "R9", "released live high");
      wr(1'b1, 8'h80);
      ticks(2);
      rd_check(8'hD6, "R8", "new snapshot low");
      rd_check(8'h03, "R8", "new snapshot high");
      rd_check(8'hD4, "R11", "live after release low");
      rd_check(8'h03, "R11", "live after release high");

      // R10 mode write halts
      load_count(8'h01, 6);
      ticks(2);
      wr(1'b1, 8'h80);
      wr(1'b1, 8'h01);
      rd_check(8'h02, "R10", "halted low (capture cleared)");
      ticks(3);
      check(chan_out === 1'b1, "R10", "out high after halt", chan_out, 1);
      rd_check(8'h00, "R10", "halted high");
      rd_check(8'h02, "R10", "still frozen low");
      rd_check(8'h00, "R10", "still frozen high");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule